// File: doc/BRIEF.md
# Locked Index/Data Watchdog Configuration Port

This block is a small configuration register file for a countdown watchdog. Software reaches it through two byte-wide ports: an index port, which selects a register, and a data port, which reads or writes the selected register. Both ports stay closed until a key is written. Two consecutive index-port writes of 0x87 open configuration mode, and an index-port write of 0xAA closes it again. A page-select register chooses a logical device page. Only the watchdog page (0x08) exposes the watchdog registers.

The watchdog holds four registers on its page:
- an enable bit;
- a count-unit select (seconds or minutes);
- an 8-bit timeout counter;
- two masks that let keyboard or mouse activity pulses reload the counter.

While enabled, the counter steps down on the unit tick. It raises a one-cycle reset request when it reaches zero, then stays at zero until software writes it again.

The seconds time base comes in as a single-cycle `sec_tick`. Minutes are derived inside the block by counting `TICKS_PER_MIN` second ticks.

Top module: `wdt_cfg_port`

## Requirements
- R1: After reset the ports are closed, `rst_req` is 0, and the page, enable, unit, timeout and mask registers are all 0.
- R2: While closed, writes to the data port change no register, and reads of either port return 0xFF.
- R3: Index-port writes control the key. Two consecutive index-port writes of 0x87 open configuration mode. A single 0x87, or a 0x87 followed by any other index-port value, leaves the ports closed and restarts the key match.
- R4: While open, an index-port write of 0xAA closes configuration mode, and later data-port writes are ignored. Any other index-port value is stored as the index and read back from the index port.
- R5: Index 0x07 is the page select and is readable and writable on every page. Indices 0x30, 0xF5, 0xF6 and 0xF7 are reachable only while the page equals 0x08. On other pages they read 0x00 and ignore writes.
- R6: Index 0x30 bit 0 enables the watchdog (1 = on). The other bits read back as 0.
- R7: Index 0xF5 bit 3 selects the unit (0 = seconds, 1 = minutes). The other bits read back as 0.
- R8: Writing index 0xF6 loads the counter and stores the value as the reload value. Reading it returns the live count.
- R9: In seconds mode with the watchdog enabled, the counter drops by one on each `sec_tick` while it is nonzero. With the watchdog disabled it holds.
- R10: In minutes mode with the watchdog enabled, the counter drops by one every `TICKS_PER_MIN` second ticks. Writing the counter restarts that tick count.
- R11: When the counter steps from 1 to 0 while enabled, `rst_req` is high for exactly one cycle. The counter then stays at 0 until it is written.
- R12: Index 0xF7 has two reload masks, bit 6 for keyboard and bit 7 for mouse; the other bits read back as 0. While a bit is set, a pulse on the matching activity input reloads a nonzero counter with the last written timeout. With the bit clear, or with the counter already at 0, the pulse has no effect.
- R13: Bus strobes to addresses other than the index and data ports change no state, and reads at those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid while it is high |
| bus_addr | input | ADDR_W | Port address (index port 0x2E, data port 0x2F by default) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0x00 when `bus_rd` is low |
| sec_tick | input | 1 | One-cycle pulse per second |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with the default port addresses and with `TICKS_PER_MIN` set to 6. This keeps every minutes-mode step, including a prescaler restart in mid-minute, within a few dozen cycles while using the same wrap logic as 60.

Every 8-bit value is swept through four paths:
- as the interrupting byte in the key sequence;
- as a data write while the ports are closed;
- as a page number;
- as write data for each watchdog field.

The expected read-back of each is computed from the field masks.

// File: rtl/wdt_cfg_pkg.sv
// Package: shared constants and types for the locked watchdog configuration port.
// Assumes 8-bit port data; all key and index codes are fixed by the register layout.
package wdt_cfg_pkg;

    localparam int DATA_W = 8;

    // Key codes written to the index port
    localparam logic [DATA_W-1:0] KEY_ENTER = 8'h87;
    localparam logic [DATA_W-1:0] KEY_EXIT  = 8'hAA;

    // Register indices
    localparam logic [DATA_W-1:0] IDX_PAGE  = 8'h07;
    localparam logic [DATA_W-1:0] IDX_EN    = 8'h30;
    localparam logic [DATA_W-1:0] IDX_UNIT  = 8'hF5;
    localparam logic [DATA_W-1:0] IDX_TMO   = 8'hF6;
    localparam logic [DATA_W-1:0] IDX_SRC   = 8'hF7;

    // Page number of the watchdog device
    localparam logic [DATA_W-1:0] PAGE_WDT  = 8'h08;

    // Field bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_UNIT  = 3;
    localparam int BIT_KBD   = 6;
    localparam int BIT_MOUSE = 7;

    // Read value of a closed port
    localparam logic [DATA_W-1:0] CLOSED_RD = 8'hFF;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_t;

endpackage

// File: rtl/wdt_key_gate.sv
// Module: wdt_key_gate
// Tracks the entry/exit key on index-port writes and reports whether configuration
// mode is open. While open, every index write other than the exit key is forwarded
// as an index load. Assumes idx_wr is a single-cycle strobe.
module wdt_key_gate
    import wdt_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cfg_open,
    output logic              idx_load
);

    key_state_t state_q;

    // Key match state machine, advanced only by index-port writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else if (idx_wr) begin
            case (state_q)
                KEY_IDLE: state_q <= (wdata == KEY_ENTER) ? KEY_HALF : KEY_IDLE;
                KEY_HALF: state_q <= (wdata == KEY_ENTER) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN: state_q <= (wdata == KEY_EXIT)  ? KEY_IDLE : KEY_OPEN;
                default:  state_q <= KEY_IDLE;
            endcase
        end
    end

    // Decode open state and the index-capture strobe
    always_comb begin
        cfg_open = (state_q == KEY_OPEN);
        idx_load = idx_wr && cfg_open && (wdata != KEY_EXIT);
    end

    // R3
    open_after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(state_q) == KEY_HALF && $past(idx_wr)));

    // R4
    exit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && cfg_open && wdata == KEY_EXIT) |=> !cfg_open);

endmodule

// File: rtl/wdt_page_regs.sv
// Module: wdt_page_regs
// Holds the index register, the page select and the watchdog-page control fields.
// It also forms the data-port read value. Writes take effect only while configuration
// mode is open. Assumes the counter value is supplied by the countdown module.
module wdt_page_regs
    import wdt_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_open_i,
    input  logic              idx_load_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [DATA_W-1:0] idx_o,
    output logic [DATA_W-1:0] data_rd_o,
    output logic              en_o,
    output logic              unit_min_o,
    output logic              kbd_mask_o,
    output logic              mouse_mask_o,
    output logic              tmo_load_o
);

    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] page_q;
    logic              en_q;
    logic              unit_q;
    logic              kbd_q;
    logic              mouse_q;
    logic              wdt_page;
    logic              wr_ok;

    // Write qualification shared by all registers
    always_comb begin
        wdt_page = (page_q == PAGE_WDT);
        wr_ok    = data_wr_i && cfg_open_i;
    end

    // Capture the register index from the index port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_load_i) begin
            idx_q <= wdata_i;
        end
    end

    // Page select register, visible on every page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_ok && idx_q == IDX_PAGE) begin
            page_q <= wdata_i;
        end
    end

    // Watchdog-page control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            unit_q  <= 1'b0;
            kbd_q   <= 1'b0;
            mouse_q <= 1'b0;
        end else if (wr_ok && wdt_page) begin
            case (idx_q)
                IDX_EN:   en_q   <= wdata_i[BIT_EN];
                IDX_UNIT: unit_q <= wdata_i[BIT_UNIT];
                IDX_SRC: begin
                    kbd_q   <= wdata_i[BIT_KBD];
                    mouse_q <= wdata_i[BIT_MOUSE];
                end
                default: ;
            endcase
        end
    end

    // Timeout load strobe toward the countdown
    always_comb begin
        tmo_load_o = wr_ok && wdt_page && (idx_q == IDX_TMO);
    end

    // Data-port read value for the selected index
    always_comb begin
        data_rd_o = '0;
        if (idx_q == IDX_PAGE) begin
            data_rd_o = page_q;
        end else if (wdt_page) begin
            case (idx_q)
                IDX_EN:   data_rd_o[BIT_EN]   = en_q;
                IDX_UNIT: data_rd_o[BIT_UNIT] = unit_q;
                IDX_TMO:  data_rd_o           = cnt_i;
                IDX_SRC: begin
                    data_rd_o[BIT_KBD]   = kbd_q;
                    data_rd_o[BIT_MOUSE] = mouse_q;
                end
                default: data_rd_o = '0;
            endcase
        end
    end

    // Drive outputs from the stored fields
    always_comb begin
        idx_o        = idx_q;
        en_o         = en_q;
        unit_min_o   = unit_q;
        kbd_mask_o   = kbd_q;
        mouse_mask_o = mouse_q;
    end

    // R2
    closed_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open_i |=> $stable(page_q));

    // R5
    off_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_page) |=> ($stable(en_q) && $stable(unit_q) && $stable(kbd_q) && $stable(mouse_q)));

endmodule

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// 8-bit watchdog counter with a seconds/minutes time base, activity reloads and a
// one-cycle reset request on expiry. Assumes sec_tick, kbd_act and mouse_act are
// single-cycle pulses and TICKS_PER_MIN is at least 2.
module wdt_countdown
    import wdt_cfg_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              unit_min_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              sec_tick_i,
    input  logic              kbd_act_i,
    input  logic              mouse_act_i,
    input  logic              kbd_mask_i,
    input  logic              mouse_mask_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              rst_req_o
);

    localparam int PRE_W = (TICKS_PER_MIN > 2) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MIN - 1);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    logic [PRE_W-1:0]  pre_q;
    logic              rst_req_q;
    logic              act_reload;
    logic              unit_tick;
    logic              step;

    // Decode reload, unit tick and decrement conditions
    always_comb begin
        act_reload = ((kbd_act_i && kbd_mask_i) || (mouse_act_i && mouse_mask_i))
                     && (cnt_q != '0);
        unit_tick  = sec_tick_i && (!unit_min_i || pre_q == PRE_LAST);
        step       = en_i && (cnt_q != '0) && unit_tick && !load_i && !act_reload;
    end

    // Minute prescaler, restarted on any counter reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load_i || act_reload || !(en_i && unit_min_i)) begin
            pre_q <= '0;
        end else if (sec_tick_i) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    // Remember the last written timeout for activity reloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (load_i) begin
            reload_q <= load_val_i;
        end
    end

    // Counter: software load, then activity reload, then decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (act_reload) begin
            cnt_q <= reload_q;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry pulse when the counter steps from one to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= step && (cnt_q == DATA_W'(1));
        end
    end

    // Drive outputs
    always_comb begin
        cnt_o     = cnt_q;
        rst_req_o = rst_req_q;
    end

    // R11
    req_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (cnt_o == '0 && $past(cnt_o) == DATA_W'(1)));

    // R11
    zero_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && !load_i) |=> cnt_o == '0);

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i && !kbd_act_i && !mouse_act_i) |=> $stable(cnt_o));

    // R10
    prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_q) < TICKS_PER_MIN);

endmodule

// File: rtl/wdt_cfg_port.sv
// Module: wdt_cfg_port (top)
// Index/data port front end for the locked watchdog register file. It decodes the
// two port addresses, gates reads while closed and wires the key gate, the register
// page and the countdown together. Assumes bus strobes last one cycle.
module wdt_cfg_port
    import wdt_cfg_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR    = 16'h002E,
    parameter logic [ADDR_W-1:0] DATA_ADDR     = 16'h002F,
    parameter int                TICKS_PER_MIN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    input  logic              kbd_act,
    input  logic              mouse_act,
    output logic              rst_req
);

    logic              idx_wr;
    logic              data_wr;
    logic              cfg_open;
    logic              idx_load;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] data_rd;
    logic              en;
    logic              unit_min;
    logic              kbd_mask;
    logic              mouse_mask;
    logic              tmo_load;
    logic [DATA_W-1:0] cnt;

    // Port address decode for write strobes
    always_comb begin
        idx_wr  = bus_wr && (bus_addr == INDEX_ADDR);
        data_wr = bus_wr && (bus_addr == DATA_ADDR);
    end

    wdt_key_gate u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    wdt_page_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_open_i   (cfg_open),
        .idx_load_i   (idx_load),
        .data_wr_i    (data_wr),
        .wdata_i      (bus_wdata),
        .cnt_i        (cnt),
        .idx_o        (idx_q),
        .data_rd_o    (data_rd),
        .en_o         (en),
        .unit_min_o   (unit_min),
        .kbd_mask_o   (kbd_mask),
        .mouse_mask_o (mouse_mask),
        .tmo_load_o   (tmo_load)
    );

    wdt_countdown #(
        .TICKS_PER_MIN (TICKS_PER_MIN)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .unit_min_i   (unit_min),
        .load_i       (tmo_load),
        .load_val_i   (bus_wdata),
        .sec_tick_i   (sec_tick),
        .kbd_act_i    (kbd_act),
        .mouse_act_i  (mouse_act),
        .kbd_mask_i   (kbd_mask),
        .mouse_mask_i (mouse_mask),
        .cnt_o        (cnt),
        .rst_req_o    (rst_req)
    );

    // Read mux: closed ports return all ones, unknown addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == INDEX_ADDR) begin
                bus_rdata = cfg_open ? idx_q : CLOSED_RD;
            end else if (bus_addr == DATA_ADDR) begin
                bus_rdata = cfg_open ? data_rd : CLOSED_RD;
            end
        end
    end

    // R13
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != INDEX_ADDR && bus_addr != DATA_ADDR) |=> $stable(cfg_open));

endmodule

// File: tb/tb_wdt_cfg_port.sv
// Bench for wdt_cfg_port: sweeps of keys, pages and fields plus timed countdown cases.
module tb_wdt_cfg_port;

    localparam int CLK_P = 10;
    localparam int TPM   = 6;
    localparam logic [15:0] A_IDX = 16'h002E;
    localparam logic [15:0] A_DAT = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        sec_tick = 1'b0;
    logic        kbd_act = 1'b0;
    logic        mouse_act = 1'b0;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    int req_hi = 0;
    bit done = 1'b0;

    wdt_cfg_port #(.TICKS_PER_MIN(TPM)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .kbd_act(kbd_act), .mouse_act(mouse_act),
        .rst_req(rst_req)
    );

    always #(CLK_P/2) clk = ~clk;

    // count cycles with the reset request high, sampled away from the edge
    always @(negedge clk) if (rst_n && rst_req) req_hi++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(A_IDX, 8'h87);
        wr(A_IDX, 8'h87);
    endtask

    task automatic wreg(input logic [7:0] i, input logic [7:0] v);
        wr(A_IDX, i);
        wr(A_DAT, v);
    endtask

    task automatic rreg(input logic [7:0] i, output logic [7:0] v);
        wr(A_IDX, i);
        rd(A_DAT, v);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) sec_tick = 1'b1;
        else if (which == 1) kbd_act = 1'b1;
        else mouse_act = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; kbd_act = 1'b0; mouse_act = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) pulse(0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_IDX, r); chk("R1 idx closed", r, 8'hFF);
        rd(A_DAT, r); chk("R1 data closed", r, 8'hFF);
        chk("R1 rst_req", rst_req, 0);
        unlock();
        rreg(8'h07, r); chk("R1 page", r, 0);
        wreg(8'h07, 8'h08);
        rreg(8'h30, r); chk("R1 en", r, 0);
        rreg(8'hF5, r); chk("R1 unit", r, 0);
        rreg(8'hF6, r); chk("R1 tmo", r, 0);
        rreg(8'hF7, r); chk("R1 masks", r, 0);

        // R2 closed-port data writes ignored (index left at page select)
        wr(A_IDX, 8'h07);
        wr(A_IDX, 8'hAA);
        for (int v = 0; v < 256; v++) begin
            wr(A_DAT, v[7:0]);
            rd(A_DAT, r); chk("R2 data read", r, 8'hFF);
            rd(A_IDX, r); chk("R2 idx read", r, 8'hFF);
        end
        unlock();
        rd(A_DAT, r); chk("R2 page kept", r, 8'h08);

        // R4 exit key closes; later data writes ignored
        wr(A_IDX, 8'hAA);
        wr(A_DAT, 8'h33);
        rd(A_IDX, r); chk("R4 closed", r, 8'hFF);
        unlock();
        rd(A_IDX, r); chk("R4 index kept", r, 8'h07);
        rd(A_DAT, r); chk("R4 page kept", r, 8'h08);
        wr(A_IDX, 8'hAA);

        // R3 single key insufficient; any interrupting byte restarts
        wr(A_IDX, 8'h00); wr(A_IDX, 8'h87);
        rd(A_IDX, r); chk("R3 single key", r, 8'hFF);
        for (int v = 0; v < 256; v++) begin
            wr(A_IDX, 8'h00);
            wr(A_IDX, 8'h87);
            wr(A_IDX, v[7:0]);
            wr(A_IDX, 8'h87);
            rd(A_IDX, r);
            chk("R3 key sweep", r, (v == 8'h87) ? 8'h87 : 8'hFF);
            if (v == 8'h87) wr(A_IDX, 8'hAA);
        end

        // R13 strobes to other addresses are ignored
        wr(16'h0030, 8'h87); wr(16'h002D, 8'h87);
        rd(A_IDX, r); chk("R13 no unlock", r, 8'hFF);
        unlock();
        wr(A_IDX, 8'h07);
        wr(16'h0030, 8'h55);
        rd(A_DAT, r); chk("R13 page kept", r, 8'h08);
        rd(16'h0030, r); chk("R13 stray read", r, 8'h00);

        // R5 page sweep
        wreg(8'hF5, 8'h08);
        for (int p = 0; p < 256; p++) begin
            wreg(8'h07, p[7:0]);
            rreg(8'hF5, r); chk("R5 gated read", r, (p == 8) ? 8'h08 : 8'h00);
            rreg(8'h07, r); chk("R5 page rb", r, p);
        end
        wreg(8'h07, 8'h09);
        wreg(8'hF5, 8'h00);
        wreg(8'h07, 8'h08);
        rreg(8'hF5, r); chk("R5 off-page write ignored", r, 8'h08);
        wreg(8'hF5, 8'h00);

        // R6 R7 R8 R12 field sweeps (counter stays stopped, no ticks)
        for (int v = 0; v < 256; v++) begin
            wreg(8'h30, v[7:0]); rreg(8'h30, r); chk("R6 en field", r, v & 8'h01);
            wreg(8'hF5, v[7:0]); rreg(8'hF5, r); chk("R7 unit field", r, v & 8'h08);
            wreg(8'hF7, v[7:0]); rreg(8'hF7, r); chk("R12 mask field", r, v & 8'hC0);
        end
        wreg(8'h30, 8'h00); wreg(8'hF5, 8'h00); wreg(8'hF7, 8'h00);
        for (int v = 0; v < 256; v++) begin
            wreg(8'hF6, v[7:0]); rreg(8'hF6, r); chk("R8 tmo rb", r, v);
        end

        // R9 disabled counter holds
        wreg(8'hF6, 8'd3);
        ticks(4);
        rreg(8'hF6, r); chk("R9 disabled hold", r, 3);

        // R9 R11 seconds countdown and expiry
        base = req_hi;
        wreg(8'hF6, 8'd5);
        wreg(8'h30, 8'h01);
        for (int i = 4; i >= 0; i--) begin
            pulse(0);
            rreg(8'hF6, r); chk("R9 sec step", r, i);
        end
        chk("R11 one-cycle pulse", req_hi - base, 1);
        ticks(3);
        rreg(8'hF6, r); chk("R11 zero sticks", r, 0);
        chk("R11 no repeat", req_hi - base, 1);

        // R10 minutes mode
        wreg(8'h30, 8'h00);
        wreg(8'hF5, 8'h08);
        wreg(8'hF6, 8'd2);
        wreg(8'h30, 8'h01);
        ticks(TPM - 1);
        rreg(8'hF6, r); chk("R10 before minute", r, 2);
        ticks(1);
        rreg(8'hF6, r); chk("R10 one minute", r, 1);
        ticks(3);
        wreg(8'hF6, 8'd2);
        ticks(TPM - 1);
        rreg(8'hF6, r); chk("R10 restart", r, 2);
        ticks(1);
        rreg(8'hF6, r); chk("R10 after restart", r, 1);
        base = req_hi;
        ticks(TPM);
        rreg(8'hF6, r); chk("R10 expiry", r, 0);
        chk("R11 minute pulse", req_hi - base, 1);

        // R12 activity reloads
        wreg(8'h30, 8'h00);
        wreg(8'hF5, 8'h00);
        wreg(8'hF7, 8'h40);
        wreg(8'hF6, 8'd9);
        wreg(8'h30, 8'h01);
        ticks(3);
        rreg(8'hF6, r); chk("R12 pre", r, 6);
        pulse(1);
        rreg(8'hF6, r); chk("R12 kbd reload", r, 9);
        ticks(1);
        pulse(2);
        rreg(8'hF6, r); chk("R12 mouse masked", r, 8);
        wreg(8'hF7, 8'h80);
        pulse(2);
        rreg(8'hF6, r); chk("R12 mouse reload", r, 9);
        ticks(1);
        pulse(1);
        rreg(8'hF6, r); chk("R12 kbd masked", r, 8);
        wreg(8'hF7, 8'hC0);
        wreg(8'hF6, 8'd1);
        ticks(1);
        pulse(1); pulse(2);
        rreg(8'hF6, r); chk("R12 expired no reload", r, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule